// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns addresses arriving from a PCI bus into system DMA addresses. Four programmable windows each hold a window base, a window mask and a translated base. The windows are compared in a fixed order against the upper address bits, and the first enabled window that matches sets the result. A matching window maps the address either directly, by splicing the translated base over the bus address, or through scatter-gather. In scatter-gather mode the block computes where a page-table entry lives, fetches that 64-bit entry over a simple request/response memory port, and builds the output from it. An address that no enabled window claims leaves the block unchanged.

Software programs the windows and a control register through a 64-bit register port. The port also has a few stub registers: an error status, an error mask and a translation-cache flush. Requests enter through a valid/ready handshake and only one is handled at a time. Results leave as a single-cycle valid pulse.

Top module: `dma_window_xlat`

## Requirements
- R1: After reset, the base, mask and translated-base registers of all four windows read as zero. The control register reads 64'h0000_0021_0010_0000, which has bit 20 set, bit 32 set and 2 in bits 39:36.
- R2: A register access with size code 3 (8 bytes) selects register index offset>>6. Window base registers are at indices 0-3, window masks at 4-7, translated bases at 8-11 and control at 12. The response, with reg_ack_o high, comes in the cycle after the request. A read returns the last value written.
- R3: An access with size code 0, 1 or 2, or to an index above 15, returns reg_err_o high with read data zero and changes no register.
- R4: Index 13 (error status) and index 15 (cache flush) read as zero and ignore writes. Index 14 (error mask) reads as zero, and a write to it is answered with an error.
- R5: Window w matches when bus address bits 31:20 equal base bits 31:20 at every position where mask bits 31:20 are zero.
- R6: Base bit 0 enables a window and base bit 1 selects scatter-gather. Windows are searched from 0 to 3 and the lowest enabled matching window wins. A disabled window that matches is skipped.
- R7: In direct mode, let P be mask bits 31:20 together with ones in bits 19:0. The output takes the translated base where P is zero and the bus address where P is one.
- R8: In scatter-gather mode, mem_addr_o is the translated base with bits 9:0 and bits 21:10 (mask bits 31:20 moved down by 10) cleared, ORed with (bus address AND (mask bits 31:20 plus bits 19:13)) shifted right by 10. mem_req_o and mem_addr_o hold until mem_gnt_i.
- R9: The scatter-gather output is (entry with bit 0 cleared) shifted left by 12, ORed with bus address bits 12:0.
- R10: Every translated output is truncated to 34 bits. With no enabled match, the output is the bus address zero-extended.
- R11: xl_ready_o is high only when the block is idle. out_valid_o is a one-cycle pulse. For a direct or unmatched request the pulse comes in the cycle after acceptance; for scatter-gather it comes in the cycle after mem_rvalid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 for write, 0 for read |
| reg_size_i | input | 2 | Access size code (3 = 8 bytes) |
| reg_offset_i | input | OFF_W | Byte offset from the block base |
| reg_wdata_i | input | 64 | Write data |
| reg_ack_o | output | 1 | Response strobe |
| reg_err_o | output | 1 | Access rejected |
| reg_rdata_o | output | 64 | Read data |
| xl_valid_i | input | 1 | Translation request valid |
| xl_ready_o | output | 1 | Translator idle, can accept a request |
| xl_addr_i | input | BUS_W | PCI bus address |
| out_valid_o | output | 1 | Result pulse |
| out_addr_o | output | DMA_W | Translated address |
| mem_req_o | output | 1 | Page-table entry fetch request |
| mem_gnt_i | input | 1 | Fetch request accepted |
| mem_addr_o | output | 64 | Entry address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 64 | Entry data |

## Verification
Each register response is sampled in the cycle after its request, in the half-cycle after the edge that registers it. A direct or unmatched translation is sampled in the first cycle after acceptance. The scatter-gather fetch is first checked in that same cycle and checked again one cycle later, with the grant still held back, to confirm that the request holds. The result is sampled in the cycle after the bench returns the entry. After every result the bench checks that the valid pulse has dropped and the translator is idle again, so any extra or missing cycle shows up as a failure.

// File: rtl/dwx_pkg.sv
`timescale 1ns/1ps
package dwx_pkg;
  localparam int unsigned DW = 64;
  localparam logic [1:0] SZ_64 = 2'd3;
  localparam logic [DW-1:0] CTRL_RST = 64'h0000_0021_0010_0000;
  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT, ST_RESP} xl_state_e;
endpackage

// File: rtl/dwx_regs.sv
`timescale 1ns/1ps
module dwx_regs
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned OFF_W   = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [1:0]                  size_i,
  input  logic [OFF_W-1:0]            offset_i,
  input  logic [DW-1:0]               wdata_i,
  output logic                        ack_o,
  output logic                        err_o,
  output logic [DW-1:0]               rdata_o,
  output logic [NUM_WIN-1:0][DW-1:0]  base_o,
  output logic [NUM_WIN-1:0][DW-1:0]  mask_o,
  output logic [NUM_WIN-1:0][DW-1:0]  tba_o
);
  localparam int IDX_W    = OFF_W - 6;
  localparam int IDX_MASK = NUM_WIN;
  localparam int IDX_TBA  = 2 * NUM_WIN;
  localparam int IDX_CTRL = 3 * NUM_WIN;
  localparam int IDX_ERR  = IDX_CTRL + 1;
  localparam int IDX_EMSK = IDX_CTRL + 2;
  localparam int IDX_INV  = IDX_CTRL + 3;

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    ctrl_q, rd_val;
  logic             acc_ok;

  assign idx = offset_i[OFF_W-1:6];

  always_comb begin
    acc_ok = 1'b0;
    rd_val = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (int'(idx) == w)            begin acc_ok = 1'b1; rd_val = base_o[w]; end
      if (int'(idx) == IDX_MASK + w) begin acc_ok = 1'b1; rd_val = mask_o[w]; end
      if (int'(idx) == IDX_TBA + w)  begin acc_ok = 1'b1; rd_val = tba_o[w];  end
    end
    if (int'(idx) == IDX_CTRL) begin acc_ok = 1'b1; rd_val = ctrl_q; end
    if (int'(idx) == IDX_ERR)  acc_ok = 1'b1;
    if (int'(idx) == IDX_EMSK) acc_ok = !we_i;
    if (int'(idx) == IDX_INV)  acc_ok = 1'b1;
    if (size_i != SZ_64)       acc_ok = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mask_o <= '0;
      tba_o  <= '0;
      ctrl_q <= CTRL_RST;
    end else if (req_i && we_i && acc_ok) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(idx) == w)            base_o[w] <= wdata_i;
        if (int'(idx) == IDX_MASK + w) mask_o[w] <= wdata_i;
        if (int'(idx) == IDX_TBA + w)  tba_o[w]  <= wdata_i;
      end
      if (int'(idx) == IDX_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      err_o   <= req_i && !acc_ok;
      rdata_o <= (req_i && acc_ok && !we_i) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/dwx_match.sv
`timescale 1ns/1ps
module dwx_match
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned DMA_W   = 34
) (
  input  logic [BUS_W-1:0]            addr_i,
  input  logic [NUM_WIN-1:0][DW-1:0]  base_i,
  input  logic [NUM_WIN-1:0][DW-1:0]  mask_i,
  input  logic [NUM_WIN-1:0][DW-1:0]  tba_i,
  output logic                        hit_o,
  output logic                        sg_o,
  output logic [DMA_W-1:0]            direct_o,
  output logic [DW-1:0]               pte_addr_o
);
  logic [DW-1:0]                   addr64;
  logic [NUM_WIN-1:0]              hit_v;
  logic [NUM_WIN-1:0][DMA_W-1:0]   direct_v;
  logic [NUM_WIN-1:0][DW-1:0]      pte_v;

  assign addr64 = DW'(addr_i);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [11:0]   wm;
    logic [DW-1:0] pass_m, direct_full, tba_clr, ba_m;
    assign wm          = mask_i[w][31:20];
    assign hit_v[w]    = (((addr64[31:20] ^ base_i[w][31:20]) & ~wm) == 12'h0) && base_i[w][0];
    assign pass_m      = {32'h0, wm, 20'hf_ffff};
    assign direct_full = (tba_i[w] & ~pass_m) | (addr64 & pass_m);
    assign direct_v[w] = direct_full[DMA_W-1:0];
    assign tba_clr     = {42'h0, wm, 10'h3ff};
    assign ba_m        = {32'h0, wm, 7'h7f, 13'h0};
    assign pte_v[w]    = (tba_i[w] & ~tba_clr) | ((addr64 & ba_m) >> 10);
  end

  // lowest index wins: scan downward so the last assignment is the winner
  always_comb begin
    hit_o      = 1'b0;
    sg_o       = 1'b0;
    direct_o   = '0;
    pte_addr_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_v[w]) begin
        hit_o      = 1'b1;
        sg_o       = base_i[w][1];
        direct_o   = direct_v[w];
        pte_addr_o = pte_v[w];
      end
    end
  end
endmodule

// File: rtl/dma_window_xlat.sv
`timescale 1ns/1ps
module dma_window_xlat
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned DMA_W   = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_size_i,
  input  logic [OFF_W-1:0]  reg_offset_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic              reg_ack_o,
  output logic              reg_err_o,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              xl_valid_i,
  output logic              xl_ready_o,
  input  logic [BUS_W-1:0]  xl_addr_i,
  output logic              out_valid_o,
  output logic [DMA_W-1:0]  out_addr_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [DW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  localparam int unsigned PG_W = 13;

  logic [NUM_WIN-1:0][DW-1:0] base, mask, tba;
  logic                       hit, sg;
  logic [DMA_W-1:0]           direct;
  logic [DW-1:0]              pte_addr;
  xl_state_e                  state_q;
  logic [PG_W-1:0]            lo_q;
  logic [DMA_W-1:0]           out_q;
  logic [DW-1:0]              maddr_q;

  dwx_regs #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .size_i   (reg_size_i),
    .offset_i (reg_offset_i),
    .wdata_i  (reg_wdata_i),
    .ack_o    (reg_ack_o),
    .err_o    (reg_err_o),
    .rdata_o  (reg_rdata_o),
    .base_o   (base),
    .mask_o   (mask),
    .tba_o    (tba)
  );

  dwx_match #(.NUM_WIN(NUM_WIN), .BUS_W(BUS_W), .DMA_W(DMA_W)) u_match (
    .addr_i     (xl_addr_i),
    .base_i     (base),
    .mask_i     (mask),
    .tba_i      (tba),
    .hit_o      (hit),
    .sg_o       (sg),
    .direct_o   (direct),
    .pte_addr_o (pte_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      out_q   <= '0;
      maddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (xl_valid_i) begin
          if (hit && sg) begin
            maddr_q <= pte_addr;
            lo_q    <= xl_addr_i[PG_W-1:0];
            state_q <= ST_MREQ;
          end else begin
            out_q   <= hit ? direct : DMA_W'(xl_addr_i);
            state_q <= ST_RESP;
          end
        end
        ST_MREQ:  if (mem_gnt_i) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rvalid_i) begin
          out_q   <= {mem_rdata_i[DMA_W-PG_W:1], lo_q};
          state_q <= ST_RESP;
        end
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign xl_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_RESP);
  assign out_addr_o  = out_q;
  assign mem_req_o   = (state_q == ST_MREQ);
  assign mem_addr_o  = maddr_q;
endmodule

// File: rtl/dwx_checker.sv
`timescale 1ns/1ps
module dwx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_req_i,
  input logic [1:0]  reg_size_i,
  input logic        reg_ack_o,
  input logic        reg_err_o,
  input logic [63:0] reg_rdata_o,
  input logic        xl_valid_i,
  input logic        xl_ready_o,
  input logic        out_valid_o,
  input logic        mem_req_o,
  input logic        mem_gnt_i,
  input logic [63:0] mem_addr_o
);
  p_ack_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i |=> reg_ack_o);
  p_no_spurious_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_req_i |=> !reg_ack_o);
  p_size_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_size_i != 2'd3) |=> (reg_err_o && reg_rdata_o == 64'h0));
  p_fetch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  p_busy_on_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !xl_ready_o);
  p_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && xl_ready_o) |=> !xl_ready_o);
  p_fetch_not_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !xl_ready_o);
endmodule

bind dma_window_xlat dwx_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_size_i  (reg_size_i),
  .reg_ack_o   (reg_ack_o),
  .reg_err_o   (reg_err_o),
  .reg_rdata_o (reg_rdata_o),
  .xl_valid_i  (xl_valid_i),
  .xl_ready_o  (xl_ready_o),
  .out_valid_o (out_valid_o),
  .mem_req_o   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/dma_window_xlat_test.sv
`timescale 1ns/1ps
module dma_window_xlat_test;
  localparam int OFF_W = 12;
  localparam int BUS_W = 32;
  localparam int DMA_W = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_req = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_size = 2'd3;
  logic [OFF_W-1:0] reg_off = '0;
  logic [63:0] reg_wdata = '0;
  logic reg_ack, reg_err;
  logic [63:0] reg_rdata;
  logic xl_valid = 1'b0;
  logic xl_ready;
  logic [BUS_W-1:0] xl_addr = '0;
  logic out_valid;
  logic [DMA_W-1:0] out_addr;
  logic mem_req;
  logic mem_gnt = 1'b0;
  logic [63:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int total = 0;
  int fails = 0;
  logic [63:0] sh_base [4];
  logic [63:0] sh_mask [4];
  logic [63:0] sh_tba  [4];

  always #2.5 clk = ~clk;

  dma_window_xlat uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_size_i(reg_size),
    .reg_offset_i(reg_off), .reg_wdata_i(reg_wdata),
    .reg_ack_o(reg_ack), .reg_err_o(reg_err), .reg_rdata_o(reg_rdata),
    .xl_valid_i(xl_valid), .xl_ready_o(xl_ready), .xl_addr_i(xl_addr),
    .out_valid_o(out_valid), .out_addr_o(out_addr),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_op(input logic we, input logic [1:0] sz, input int idx,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_size = sz;
    reg_off = OFF_W'(idx * 64); reg_wdata = wd;
    @(negedge clk);
    reg_req = 1'b0;
    rd = reg_rdata;
    er = reg_err | !reg_ack;
  endtask

  task automatic wr(input int idx, input logic [63:0] v);
    logic [63:0] rd; logic er;
    reg_op(1'b1, 2'd3, idx, v, rd, er);
    if (idx < 4) sh_base[idx] = v;
    else if (idx < 8) sh_mask[idx-4] = v;
    else if (idx < 12) sh_tba[idx-8] = v;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [63:0] exp);
    logic [63:0] rd; logic er;
    reg_op(1'b0, 2'd3, idx, 64'h0, rd, er);
    chk(req, {63'h0, er}, 64'h0);
    chk(req, rd, exp);
  endtask

  function automatic logic [63:0] pte_of(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'h0000_0000_1357_9BDF;
  endfunction

  // expected behaviour computed from the requirement text
  task automatic model(input logic [31:0] a, output logic sg, output logic [63:0] pa,
                       output logic [DMA_W-1:0] res);
    logic [63:0] a64, cm, pm, tc, bm, full;
    logic done;
    a64 = {32'h0, a};
    sg = 1'b0; pa = '0; res = DMA_W'(a64); done = 1'b0;
    for (int w = 0; w < 4; w++) begin
      cm = ~sh_mask[w] & 64'hFFF0_0000;
      if (!done && ((a64 & cm) == (sh_base[w] & cm)) && sh_base[w][0]) begin
        done = 1'b1;
        if (sh_base[w][1]) begin
          sg = 1'b1;
          tc = ((sh_mask[w] & 64'hFFF0_0000) >> 10) | 64'h3FF;
          bm = (sh_mask[w] & 64'hFFF0_0000) | (64'h7F << 13);
          pa = (sh_tba[w] & ~tc) | ((a64 & bm) >> 10);
          full = ((pte_of(pa) & ~64'h1) << 12) | (a64 & 64'h1FFF);
        end else begin
          pm = (sh_mask[w] & 64'hFFF0_0000) | 64'hF_FFFF;
          full = (sh_tba[w] & ~pm) | (a64 & pm);
        end
        res = full[DMA_W-1:0];
      end
    end
  endtask

  task automatic xlat(input logic [31:0] a);
    logic sg; logic [63:0] pa; logic [DMA_W-1:0] exp;
    model(a, sg, pa, exp);
    @(negedge clk);
    xl_valid = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_valid = 1'b0;
    if (sg) begin
      chk("R8 fetch request", {63'h0, mem_req}, 64'h1);
      chk("R8 entry address", mem_addr, pa);
      @(negedge clk);
      chk("R8 request held", {63'h0, mem_req}, 64'h1);
      chk("R8 address held", mem_addr, pa);
      mem_gnt = 1'b1;
      @(negedge clk);
      mem_gnt = 1'b0;
      chk("R11 no early result", {63'h0, out_valid, mem_req}, 64'h0);
      @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = pte_of(pa);
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0;
      chk("R11 sg valid", {63'h0, out_valid}, 64'h1);
      chk("R9 sg result", {30'h0, out_addr}, {30'h0, exp});
    end else begin
      chk("R11 direct valid", {63'h0, out_valid}, 64'h1);
      chk("R7 R10 direct result", {30'h0, out_addr}, {30'h0, exp});
    end
    @(negedge clk);
    chk("R11 pulse end", {62'h0, out_valid, xl_ready}, 64'h1);
  endtask

  task automatic sweep();
    logic [31:0] lows [4];
    lows[0] = 32'h0000_0000; lows[1] = 32'h0012_3456;
    lows[2] = 32'h0FFF_FFFF; lows[3] = 32'h0000_1FFF;
    for (int hi = 0; hi < 16; hi++)
      for (int k = 0; k < 4; k++)
        xlat((32'(hi) << 28) | lows[k]);
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] rd; logic er;
    for (int w = 0; w < 4; w++) begin sh_base[w] = 0; sh_mask[w] = 0; sh_tba[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {61'h0, xl_ready, out_valid, mem_req}, 64'h4);
    for (int i = 0; i < 12; i++) rd_chk("R1 window reset", i, 64'h0);
    rd_chk("R1 control reset", 12, 64'h0000_0021_0010_0000);

    // R2 readback of every register
    for (int i = 0; i < 12; i++) wr(i, 64'hA5A5_0000_0000_0000 | (64'(i) << 40) | (64'(i) * 64'h1111_1111));
    wr(12, 64'hDEAD_BEEF_0BAD_F00D);
    for (int i = 0; i < 12; i++)
      rd_chk("R2 readback", i, 64'hA5A5_0000_0000_0000 | (64'(i) << 40) | (64'(i) * 64'h1111_1111));
    rd_chk("R2 control readback", 12, 64'hDEAD_BEEF_0BAD_F00D);

    // R3 bad sizes and unknown indices
    for (int s = 0; s < 3; s++) begin
      reg_op(1'b1, 2'(s), 5, 64'h1234, rd, er);
      chk("R3 size write err", {63'h0, er}, 64'h1);
      reg_op(1'b0, 2'(s), 5, 64'h0, rd, er);
      chk("R3 size read err", {63'h0, er}, 64'h1);
      chk("R3 size read data", rd, 64'h0);
    end
    reg_op(1'b1, 2'd3, 16 + 5, 64'h1234, rd, er);
    chk("R3 unknown write err", {63'h0, er}, 64'h1);
    reg_op(1'b0, 2'd3, 63, 64'h0, rd, er);
    chk("R3 unknown read err", {63'h0, er}, 64'h1);
    chk("R3 unknown read data", rd, 64'h0);
    rd_chk("R3 state kept", 5, 64'hA5A5_0500_5555_5555);
    rd_chk("R3 control kept", 12, 64'hDEAD_BEEF_0BAD_F00D);

    // R4 stub registers
    reg_op(1'b1, 2'd3, 13, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
    chk("R4 error write accepted", {63'h0, er}, 64'h0);
    rd_chk("R4 error reads zero", 13, 64'h0);
    reg_op(1'b1, 2'd3, 15, 64'hFFFF, rd, er);
    chk("R4 flush write accepted", {63'h0, er}, 64'h0);
    rd_chk("R4 flush reads zero", 15, 64'h0);
    rd_chk("R4 errmask reads zero", 14, 64'h0);
    reg_op(1'b1, 2'd3, 14, 64'h1, rd, er);
    chk("R4 errmask write err", {63'h0, er}, 64'h1);
    rd_chk("R4 windows untouched", 0, 64'hA5A5_0000_0000_0000);

    // config A: windows matching but all disabled (R6, R10)
    for (int w = 0; w < 4; w++) begin
      wr(w, 64'h4000_0002 + (64'(w) << 28));
      wr(4 + w, 64'h0FF0_0000);
      wr(8 + w, 64'h3_0000_0000);
    end
    sweep();

    // config B: direct, disabled overlap, narrower window, scatter-gather, truncation
    wr(0, 64'h4000_0001); wr(4, 64'h0FF0_0000); wr(8, 64'hFFFF_FFF7_0000_0000);
    wr(1, 64'h5000_0000); wr(5, 64'h0FF0_0000); wr(9, 64'h1_1000_0000);
    wr(2, 64'h5000_0001); wr(6, 64'h0F00_0000); wr(10, 64'h2_A000_0000);
    wr(3, 64'h8000_0003); wr(7, 64'h0FF0_0000); wr(11, 64'h0000_00F0_1234_5678);
    sweep();

    // config C: two enabled overlapping windows, lower index wins (R5, R6)
    wr(0, 64'h4000_0000);
    wr(1, 64'h4000_0001); wr(5, 64'h0);         wr(9, 64'h3_FFF0_0000);
    wr(2, 64'h4000_0003); wr(6, 64'h3FF0_0000); wr(10, 64'h0000_0000_ABCD_E000);
    wr(3, 64'h8000_0002);
    sweep();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule